// File: doc/BRIEF.md
# Bit-Granular Stream-to-Image Mapper

This block sits beside the byte stream of a passing network frame and links bit ranges of that stream to bit positions in a small local image of device data. It holds a table of mapping entries. Each entry names a start bit in the logical stream, a start bit in the local image, a length of 1 to 64 bits and a direction. For each payload byte that goes past, every enabled entry is checked against the byte's eight logical bits.

Where an entry of the read direction covers a bit, the outgoing byte takes the device's bit from the `in_img` vector instead of the frame's bit. All other bits pass through unchanged. Where an entry of the write direction covers a bit, the frame's bit is held in a pending store. The pending store reaches the `out_img` vector only when the frame closes with a good checksum. Two flags report, together with each processed byte, whether any read or write mapping touched it, so that a frame counter elsewhere can be advanced.

Top module: `bmu_bitmap_unit`

## Requirements
- R1: After reset `out_valid`, `byte_out`, `hit_rd`, `hit_wr` and `out_img` are all zero, and every table entry is disabled.
- R2: A write with `cfg_we` high stores `cfg_en`, `cfg_dir` (1 = read from device into frame, 0 = write from frame into device), `cfg_lstart`, `cfg_pstart` and `cfg_len_m1` into entry `cfg_idx`. The mapping length is `cfg_len_m1`+1. A byte accepted in the same cycle as the write still uses the old contents; the next byte uses the new ones.
- R3: Bit b (0 = LSB) of the byte at `byte_addr` A has logical bit number 8A+b. An entry covers logical bits lstart through lstart+len-1. A covered bit maps to image bit (pstart + logical - lstart) modulo the image size of 128 bits.
- R4: For a byte accepted with `byte_valid` high, `byte_out` shows the processed byte one cycle later with `out_valid` high. Each bit covered by an enabled read entry carries `in_img` at the mapped image bit.
- R5: Bits of an accepted byte not covered by any enabled read entry appear on `byte_out` unchanged.
- R6: When several enabled read entries cover the same bit, the entry with the lowest index supplies it.
- R7: Bits covered by enabled write entries are held pending. On `frame_end` with `crc_ok` high, every pending bit is written to its image bit in `out_img`. On `frame_end` with `crc_ok` low, the pending bits are dropped. `out_img` does not change in any other cycle.
- R8: A byte accepted in the same cycle as `frame_end` takes part in that commit or discard. Nothing remains pending after `frame_end`.
- R9: `hit_rd` (or `hit_wr`) is high for one cycle, aligned with `out_valid`, exactly when at least one bit of that byte was covered by an enabled read (or write) entry. Both flags are low when no byte was accepted.
- R10: A disabled entry changes neither `byte_out`, nor the flags, nor `out_img`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 2 | Entry index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_dir | input | 1 | 1 = device to frame, 0 = frame to device |
| cfg_lstart | input | 16 | Logical start bit |
| cfg_pstart | input | 7 | Image start bit |
| cfg_len_m1 | input | 6 | Length in bits minus one |
| byte_valid | input | 1 | A payload byte is present |
| byte_addr | input | 13 | Logical byte number of the payload byte |
| byte_in | input | 8 | Incoming payload byte |
| frame_end | input | 1 | Frame closes this cycle |
| crc_ok | input | 1 | Checksum of the closing frame is good |
| in_img | input | 128 | Device data offered to read entries |
| byte_out | output | 8 | Outgoing payload byte |
| out_valid | output | 1 | `byte_out` holds a processed byte |
| hit_rd | output | 1 | A read mapping touched the byte |
| hit_wr | output | 1 | A write mapping touched the byte |
| out_img | output | 128 | Committed device data from write entries |

## Verification
The last payload byte of a frame and the close of that frame can arrive in the same cycle. In that case the byte's captured bits must join the commit or the discard that happens on the same edge. The bench provokes this by raising `frame_end` together with `byte_valid`, both in directed cases and in random frames, with good and bad checksums. It judges the result on `out_img` one cycle later against a bench model that first folds in the byte and then applies the commit. A second collision, a table write in the same cycle as a byte, is driven as well; the byte must follow the old entry contents.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  parameter int LBIT_W   = 16;
  parameter int MEM_BITS = 128;
  parameter int PBIT_W   = $clog2(MEM_BITS);
  parameter int LEN_W    = 6;
  parameter int BADDR_W  = LBIT_W - 3;

  typedef struct packed {
    logic              en;
    logic              dir;
    logic [LBIT_W-1:0] lstart;
    logic [PBIT_W-1:0] pstart;
    logic [LEN_W-1:0]  len_m1;
  } map_ent_t;
endpackage

// File: rtl/bmu_cfg_table.sv
module bmu_cfg_table
  import bmu_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  map_ent_t         cfg_ent,
  output map_ent_t         ent_o [NUM_ENT]
);
  map_ent_t ent_q [NUM_ENT];
  map_ent_t ent_n [NUM_ENT];

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      ent_n[i] = ent_q[i];
      if (cfg_we && (int'(cfg_idx) == i)) ent_n[i] = cfg_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= ent_n[i];
    end
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_out
    assign ent_o[i] = ent_q[i];
    // R2: an entry changes only on a write to its own index
    p_entry_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && int'(cfg_idx) == i) |=> $stable(ent_q[i]));
  end
endmodule

// File: rtl/bmu_lane_match.sv
module bmu_lane_match
  import bmu_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  map_ent_t                     ent,
  input  logic [BADDR_W-1:0]           byte_addr,
  output logic [7:0]                   cover_o,
  output logic [7:0][PBIT_W-1:0]       pidx_o
);
  logic [LEN_W:0] len_v;
  assign len_v = (LEN_W+1)'(ent.len_m1) + (LEN_W+1)'(1);

  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic [LBIT_W-1:0] lbit;
    logic [LBIT_W:0]   diff;
    assign lbit = {byte_addr, 3'(b)};
    assign diff = {1'b0, lbit} - {1'b0, ent.lstart};
    assign cover_o[b] = ent.en && !diff[LBIT_W] &&
                        (diff[LBIT_W-1:0] < LBIT_W'(len_v));
    assign pidx_o[b] = ent.pstart + diff[PBIT_W-1:0];
  end

  // R3: a byte never has more covered bits than the entry length
  p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cover_o != 8'h00) |-> ($countones(cover_o) <= int'(ent.len_m1) + 1));
  // R10: a disabled entry covers nothing
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cover_o != 8'h00) |-> ent.en);
endmodule

// File: rtl/bmu_capture.sv
module bmu_capture
  import bmu_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  byte_valid,
  input  logic [7:0]                            byte_in,
  input  logic [NUM_ENT-1:0][7:0]               wr_cover,
  input  logic [NUM_ENT-1:0][7:0][PBIT_W-1:0]   pidx,
  input  logic                                  frame_end,
  input  logic                                  crc_ok,
  output logic [MEM_BITS-1:0]                   out_img
);
  logic [MEM_BITS-1:0] pend_val_q, pend_msk_q, img_q;
  logic [MEM_BITS-1:0] st_val, st_msk;
  logic [MEM_BITS-1:0] pend_val_n, pend_msk_n, img_n;
  logic                pend_ce, img_ce;

  always_comb begin
    st_val = pend_val_q;
    st_msk = pend_msk_q;
    if (byte_valid) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        for (int b = 0; b < 8; b++) begin
          if (wr_cover[e][b]) begin
            st_val[pidx[e][b]] = byte_in[b];
            st_msk[pidx[e][b]] = 1'b1;
          end
        end
      end
    end
    pend_val_n = frame_end ? '0 : st_val;
    pend_msk_n = frame_end ? '0 : st_msk;
    img_n      = (img_q & ~st_msk) | (st_val & st_msk);
    pend_ce    = byte_valid | frame_end;
    img_ce     = frame_end & crc_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_val_q <= '0;
      pend_msk_q <= '0;
    end else if (pend_ce) begin
      pend_val_q <= pend_val_n;
      pend_msk_q <= pend_msk_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      img_q <= '0;
    else if (img_ce) img_q <= img_n;
  end

  assign out_img = img_q;

  // R7: the image moves only on a frame close with good checksum
  p_img_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && crc_ok) |=> $stable(img_q));
  // R8: nothing stays pending past a frame close
  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pend_msk_q == '0));
  // R7: a commit leaves bits that were not pending untouched
  p_commit_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !byte_valid) |=>
      (((img_q ^ $past(img_q)) & ~$past(pend_msk_q)) == '0));
endmodule

// File: rtl/bmu_bitmap_unit.sv
module bmu_bitmap_unit
  import bmu_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_en,
  input  logic                cfg_dir,
  input  logic [LBIT_W-1:0]   cfg_lstart,
  input  logic [PBIT_W-1:0]   cfg_pstart,
  input  logic [LEN_W-1:0]    cfg_len_m1,
  input  logic                byte_valid,
  input  logic [BADDR_W-1:0]  byte_addr,
  input  logic [7:0]          byte_in,
  input  logic                frame_end,
  input  logic                crc_ok,
  input  logic [MEM_BITS-1:0] in_img,
  output logic [7:0]          byte_out,
  output logic                out_valid,
  output logic                hit_rd,
  output logic                hit_wr,
  output logic [MEM_BITS-1:0] out_img
);
  map_ent_t cfg_ent;
  map_ent_t ent [NUM_ENT];

  assign cfg_ent = '{en: cfg_en, dir: cfg_dir, lstart: cfg_lstart,
                     pstart: cfg_pstart, len_m1: cfg_len_m1};

  bmu_cfg_table #(.NUM_ENT(NUM_ENT)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ent(cfg_ent), .ent_o(ent)
  );

  logic [NUM_ENT-1:0][7:0]             cov, rd_cov, wr_cov;
  logic [NUM_ENT-1:0][7:0][PBIT_W-1:0] pidx;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_lane
    bmu_lane_match u_lane (
      .clk(clk), .rst_n(rst_n), .ent(ent[e]), .byte_addr(byte_addr),
      .cover_o(cov[e]), .pidx_o(pidx[e])
    );
    assign rd_cov[e] = cov[e] & {8{ent[e].dir}};
    assign wr_cov[e] = cov[e] & {8{~ent[e].dir}};
  end

  bmu_capture #(.NUM_ENT(NUM_ENT)) u_cap (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .wr_cover(wr_cov), .pidx(pidx), .frame_end(frame_end), .crc_ok(crc_ok),
    .out_img(out_img)
  );

  // merge: descending scan so the lowest index is applied last
  logic [7:0] merged;
  logic       any_rd, any_wr;

  always_comb begin
    merged = byte_in;
    for (int b = 0; b < 8; b++) begin
      for (int e = NUM_ENT - 1; e >= 0; e--) begin
        if (rd_cov[e][b]) merged[b] = in_img[pidx[e][b]];
      end
    end
    any_rd = |rd_cov;
    any_wr = |wr_cov;
  end

  logic [7:0] bo_q, bo_n;
  logic       ov_q, hr_q, hw_q;
  logic       ov_n, hr_n, hw_n;

  always_comb begin
    bo_n = merged;
    ov_n = byte_valid;
    hr_n = byte_valid & any_rd;
    hw_n = byte_valid & any_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bo_q <= '0;
    else if (byte_valid) bo_q <= bo_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      hr_q <= 1'b0;
      hw_q <= 1'b0;
    end else begin
      ov_q <= ov_n;
      hr_q <= hr_n;
      hw_q <= hw_n;
    end
  end

  assign byte_out  = bo_q;
  assign out_valid = ov_q;
  assign hit_rd    = hr_q;
  assign hit_wr    = hw_q;

  // R5: with no read hit the byte leaves as it came in
  p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hit_rd) |-> (byte_out == $past(byte_in)));
  // R9: flags only accompany a processed byte
  p_hit_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rd || hit_wr) |-> out_valid);
  // R9: no byte accepted, no flag next cycle
  p_hit_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !(hit_rd || hit_wr || out_valid));
endmodule

// File: tb/test_bmu_bitmap_unit.sv
`timescale 1ns/1ps
module test_bmu_bitmap_unit;
  import bmu_pkg::*;
  localparam int NE = 4;
  localparam int MB = MEM_BITS;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_en, cfg_dir;
  logic [1:0] cfg_idx;
  logic [LBIT_W-1:0] cfg_lstart;
  logic [PBIT_W-1:0] cfg_pstart;
  logic [LEN_W-1:0] cfg_len_m1;
  logic byte_valid, frame_end, crc_ok;
  logic [BADDR_W-1:0] byte_addr;
  logic [7:0] byte_in, byte_out;
  logic [MB-1:0] in_img, out_img;
  logic out_valid, hit_rd, hit_wr;

  always #2.5 clk = ~clk;

  bmu_bitmap_unit i_bmu_bitmap_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_dir(cfg_dir), .cfg_lstart(cfg_lstart),
    .cfg_pstart(cfg_pstart), .cfg_len_m1(cfg_len_m1),
    .byte_valid(byte_valid), .byte_addr(byte_addr), .byte_in(byte_in),
    .frame_end(frame_end), .crc_ok(crc_ok), .in_img(in_img),
    .byte_out(byte_out), .out_valid(out_valid), .hit_rd(hit_rd),
    .hit_wr(hit_wr), .out_img(out_img)
  );

  int total = 0, bad = 0;
  bit m_en [NE], m_dir [NE];
  int m_ls [NE], m_ps [NE], m_lm [NE];
  logic [MB-1:0] img_m = '0, pv_m = '0, pm_m = '0;
  logic [7:0] eo;
  logic ehr, ehw;

  task automatic chk(input bit ok, input string req, input logic [MB-1:0] act,
                     input logic [MB-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_cfg(input int i, input bit en, input bit dir,
                           input int ls, input int ps, input int lm);
    m_en[i] = en; m_dir[i] = dir; m_ls[i] = ls; m_ps[i] = ps; m_lm[i] = lm;
  endtask

  task automatic model_byte(input int a, input logic [7:0] d);
    int lb, p;
    eo = d; ehr = 1'b0; ehw = 1'b0;
    for (int b = 0; b < 8; b++) begin
      lb = a * 8 + b;
      for (int e = NE - 1; e >= 0; e--)
        if (m_en[e] && m_dir[e] && lb >= m_ls[e] && lb <= m_ls[e] + m_lm[e]) begin
          p = (m_ps[e] + lb - m_ls[e]) % MB;
          eo[b] = in_img[p]; ehr = 1'b1;
        end
    end
    for (int e = 0; e < NE; e++)
      for (int b = 0; b < 8; b++) begin
        lb = a * 8 + b;
        if (m_en[e] && !m_dir[e] && lb >= m_ls[e] && lb <= m_ls[e] + m_lm[e]) begin
          p = (m_ps[e] + lb - m_ls[e]) % MB;
          pv_m[p] = d[b]; pm_m[p] = 1'b1; ehw = 1'b1;
        end
      end
  endtask

  task automatic drive_cfg(input int i, input bit en, input bit dir,
                           input int ls, input int ps, input int lm);
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_en = en; cfg_dir = dir;
    cfg_lstart = LBIT_W'(ls); cfg_pstart = PBIT_W'(ps); cfg_len_m1 = LEN_W'(lm);
  endtask

  task automatic check_byte(input string req);
    chk(out_valid === 1'b1, {req, " out_valid"}, MB'(out_valid), 1);
    chk(byte_out === eo, {req, " byte_out"}, MB'(byte_out), MB'(eo));
    chk(hit_rd === ehr, "R9 hit_rd", MB'(hit_rd), MB'(ehr));
    chk(hit_wr === ehw, "R9 hit_wr", MB'(hit_wr), MB'(ehw));
    chk(out_img === img_m, "R7 out_img hold", out_img, img_m);
  endtask

  // all tasks below start and end at a falling edge
  task automatic do_cfg(input int i, input bit en, input bit dir,
                        input int ls, input int ps, input int lm);
    drive_cfg(i, en, dir, ls, ps, lm);
    model_cfg(i, en, dir, ls, ps, lm);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int a, input logic [7:0] d, input string req);
    byte_valid = 1'b1; byte_addr = BADDR_W'(a); byte_in = d;
    model_byte(a, d);
    @(negedge clk);
    byte_valid = 1'b0;
    check_byte(req);
  endtask

  // R2: table write and byte in the same cycle; byte uses old contents
  task automatic cfg_and_send(input int i, input bit en, input bit dir,
                              input int ls, input int ps, input int lm,
                              input int a, input logic [7:0] d);
    drive_cfg(i, en, dir, ls, ps, lm);
    byte_valid = 1'b1; byte_addr = BADDR_W'(a); byte_in = d;
    model_byte(a, d);
    model_cfg(i, en, dir, ls, ps, lm);
    @(negedge clk);
    cfg_we = 1'b0; byte_valid = 1'b0;
    check_byte("R2 same-cycle write");
  endtask

  task automatic fend(input bit ok, input bit with_byte, input int a,
                      input logic [7:0] d);
    frame_end = 1'b1; crc_ok = ok;
    if (with_byte) begin
      byte_valid = 1'b1; byte_addr = BADDR_W'(a); byte_in = d;
      model_byte(a, d);
    end
    if (ok) img_m = (img_m & ~pm_m) | (pv_m & pm_m);
    pv_m = '0; pm_m = '0;
    @(negedge clk);
    frame_end = 1'b0; crc_ok = 1'b0; byte_valid = 1'b0;
    if (with_byte) check_byte("R8 byte with close");
    chk(out_img === img_m, ok ? "R7 commit" : "R7 discard", out_img, img_m);
    chk(!out_valid || with_byte, "R9 idle", MB'(out_valid), 0);
  endtask

  function automatic logic [MB-1:0] rnd_img();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NE; i++) model_cfg(i, 0, 0, 0, 0, 0);
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_en = 0; cfg_dir = 0;
    cfg_lstart = 0; cfg_pstart = 0; cfg_len_m1 = 0; byte_valid = 0;
    byte_addr = 0; byte_in = 0; frame_end = 0; crc_ok = 0;
    in_img = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid === 0 && hit_rd === 0 && hit_wr === 0, "R1 flags",
        MB'({out_valid, hit_rd, hit_wr}), 0);
    chk(byte_out === 8'h00, "R1 byte_out", MB'(byte_out), 0);
    chk(out_img === '0, "R1 out_img", out_img, '0);
    // R1 / R10: empty table passes bytes
    send(0, 8'hA5, "R1 R5 empty table");
    // R3 R4: read entry covering logical bits 3..12
    do_cfg(0, 1, 1, 3, 5, 9);
    send(0, 8'h00, "R3 R4 first byte");
    send(1, 8'hFF, "R3 R4 second byte");
    send(2, 8'h5A, "R5 outside range");
    // R6: entry 1 overlaps bits 6..9 with another source
    do_cfg(1, 1, 1, 6, 100, 3);
    send(0, 8'h3C, "R6 priority");
    send(1, 8'hC3, "R6 priority");
    // R10: disabled entry spanning everything
    do_cfg(2, 0, 1, 0, 60, 63);
    send(0, 8'h96, "R10 disabled");
    send(3, 8'h69, "R10 disabled");
    // R7: 64-bit write entry over bytes 2..9, wrapping past image end
    do_cfg(3, 1, 0, 16, 100, 63);
    for (int a = 2; a < 10; a++) send(a, 8'(8'h11 * a), "R3 R7 capture");
    fend(1, 0, 0, 8'h00);
    for (int a = 2; a < 10; a++) send(a, 8'hE7, "R7 capture");
    fend(0, 0, 0, 8'h00);
    send(4, 8'h0F, "R7 capture");
    fend(1, 1, 9, 8'hF0);
    // R8: close with bad checksum together with last byte
    send(5, 8'hAA, "R8 capture");
    fend(0, 1, 6, 8'h55);
    // R2: write lands while a byte passes
    cfg_and_send(0, 1, 1, 0, 0, 7, 0, 8'h81);
    send(0, 8'h81, "R2 new entry used");
    // random frames
    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < NE; i++)
        do_cfg(i, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 240), $urandom_range(0, MB - 1),
               $urandom_range(0, 63));
      in_img = rnd_img();
      begin
        int n, a0;
        n = $urandom_range(4, 24);
        a0 = $urandom_range(0, 20);
        for (int k = 0; k < n; k++) begin
          if ($urandom_range(0, 15) == 0)
            cfg_and_send($urandom_range(0, NE - 1), 1, $urandom_range(0, 1) == 1,
                         $urandom_range(0, 240), $urandom_range(0, MB - 1),
                         $urandom_range(0, 63), a0 + k, 8'($urandom));
          else
            send(a0 + k, 8'($urandom), "R4 R5 R6 random");
        end
        fend($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
             a0 + n, 8'($urandom));
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule